// File: doc/BRIEF.md
# Two-Tap Oscillator Cycle Modulator

This block turns a coarse, discrete-step oscillator into one with a fractional average frequency. On every oscillator cycle it picks either the base tap `n` or the next tap up, `n+1`. The choice follows a 5-bit modulation code `m` over a frame of 32 cycles that repeats without a break. Exactly `m` cycles of each frame use the upper tap. Adjacent taps are roughly 10% apart, so mixing them this way brings the long-term frequency error down to a small fraction of one tap step.

The upper-tap cycles are spread evenly through the frame. A phase accumulator adds `m` every cycle, and a carry out of the 32-count range marks an upper-tap cycle. The base tap and modulation codes are sampled only at a frame boundary, so a frame never mixes two settings. The codes can be driven directly, which gives open-loop fractional tap setting with no frequency loop around the block. When the base tap is already at its top value, the upper tap clamps to that same value.

Top module: `tapmod_core`

## Requirements
- R1: A frame lasts 32 cycles and repeats continuously. `frame_start` is 1 on frame cycle 0 and 0 on the other 31 cycles.
- R2: In every frame whose latched base tap is below 31, `upper_active` is 1 on exactly `m` of the 32 cycles. `m` is the latched modulation code.
- R3: On frame cycle `k` (0 to 31), `upper_active` is 1 exactly when floor((k+1)·m/32) > floor(k·m/32). `sel_tap` is `n+1` on those cycles and `n` on all other cycles.
- R4: A latched modulation code of 0 gives `upper_active` = 0 and `sel_tap` = `n` on all 32 cycles of the frame.
- R5: `tap_code` and `mod_code` are sampled only on the clock edge that ends frame cycle 31, or on the first edge after reset is released. That sampled pair governs the whole next frame, and a change at any other time has no effect on the current frame.
- R6: While the latched base tap is 31, `sel_tap` stays 31 and `upper_active` stays 0 on every cycle, whatever the modulation code.
- R7: Reset is synchronous and active low. While it is held, `sel_tap` = 0, `upper_active` = 0 and `frame_start` = 0. The first edge with `rst_n` high samples the codes and starts frame cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one cycle is one modulation step |
| rst_n | input | 1 | Synchronous active-low reset |
| tap_code | input | 5 | Base tap `n`, sampled at frame boundaries |
| mod_code | input | 5 | Modulation code `m`: number of upper-tap cycles per frame |
| sel_tap | output | 5 | Tap applied in the current cycle |
| upper_active | output | 1 | 1 when the current cycle uses `n+1` |
| frame_start | output | 1 | 1 on the first cycle of each 32-cycle frame |

## Verification
The embedded assertions check several rules on every cycle:
- the frame wraps from its last cycle back to cycle 0;
- the latched codes hold still between boundaries;
- each frame's upper-cycle tally equals `m`;
- the selected tap is always `n+1` on an upper cycle;
- a zero modulation code never raises `upper_active`;
- a saturated base tap pins the output.

Some behaviour only the bench's scenarios can show. These are the exact position of every upper cycle in the frame, and that a code changed mid-frame first appears on the next frame and not before. They also include the output values during reset and the restart after a reset in the middle of a frame. Mixed random and directed codes cover `m` = 0, 1, 16 and 31 and base taps 30 and 31.

// File: rtl/tapmod_pkg.sv
// Package tapmod_pkg
// Holds the default widths and the shared tap-choice type for the
// two-tap cycle modulator. It assumes that the frame length is a power of
// two equal to 2**MOD_W.
package tapmod_pkg;

    localparam int TAPMOD_TAP_W = 5;
    localparam int TAPMOD_MOD_W = 5;

    // Which of the two adjacent taps a cycle uses
    typedef enum logic {
        PICK_BASE  = 1'b0,
        PICK_UPPER = 1'b1
    } pick_e;

endpackage

// File: rtl/tapmod_frame_ctr.sv
// Module tapmod_frame_ctr
// Counts the cycles of the modulation frame, which is 2**MOD_W cycles long.
// It flags the first cycle (frame_first) and the last cycle (frame_last).
// Reset parks the count on the last cycle, so the first edge after reset
// is a frame boundary. It assumes a synchronous active-low reset.
module tapmod_frame_ctr #(
    parameter int MOD_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             frame_first,
    output logic             frame_last,
    output logic [MOD_W-1:0] cyc_idx
);

    localparam logic [MOD_W-1:0] LAST_IDX  = '1;
    localparam logic [MOD_W-1:0] FIRST_IDX = '0;

    logic [MOD_W-1:0] cnt_q;

    // Purpose: advance the cycle index and wrap at the frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= LAST_IDX;
        end else if (cnt_q == LAST_IDX) begin
            cnt_q <= FIRST_IDX;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: decode the frame boundary flags (no flag while in reset)
    always_comb begin
        frame_first = rst_n && (cnt_q == FIRST_IDX);
        frame_last  = (cnt_q == LAST_IDX);
        cyc_idx     = cnt_q;
    end

    // R1: the last frame cycle is always followed by a frame start
    p_frame_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |=> frame_first);

    // R1: a frame start is never two cycles in a row
    p_single_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_first |=> !frame_first);

endmodule

// File: rtl/tapmod_code_hold.sv
// Module tapmod_code_hold
// Samples the base tap code and the modulation code on the load strobe and
// holds them for the whole next frame. This keeps a frame from mixing two
// settings. It assumes that load is the frame's last-cycle flag from the
// frame counter, and it clears both codes in reset.
module tapmod_code_hold #(
    parameter int TAP_W = 5,
    parameter int MOD_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TAP_W-1:0] tap_in,
    input  logic [MOD_W-1:0] mod_in,
    output logic [TAP_W-1:0] tap_q,
    output logic [MOD_W-1:0] mod_q
);

    // Purpose: capture both codes only at a frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q <= '0;
            mod_q <= '0;
        end else if (load) begin
            tap_q <= tap_in;
            mod_q <= mod_in;
        end
    end

    // R5: the held codes never change away from a frame boundary
    p_codes_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(tap_q) && $stable(mod_q)));

endmodule

// File: rtl/tapmod_accum.sv
// Module tapmod_accum
// A phase accumulator that adds the modulation code once per cycle. A carry
// out of the 2**MOD_W range marks an upper-tap cycle. The phase is cleared at
// each frame boundary, so every frame carries exactly mod_q times, evenly
// spaced. It assumes that restart coincides with the code-hold load strobe.
module tapmod_accum #(
    parameter int MOD_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [MOD_W-1:0] mod_q,
    output logic             carry
);

    localparam int SUM_W = MOD_W + 1;

    logic [MOD_W-1:0] phase_q;
    logic [SUM_W-1:0] sum;

    // Purpose: form this cycle's phase sum and its carry out
    always_comb begin
        sum   = {1'b0, phase_q} + {1'b0, mod_q};
        carry = sum[MOD_W];
    end

    // Purpose: update the phase, clearing it at the frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else begin
            phase_q <= sum[MOD_W-1:0];
        end
    end

    // Checker state: carries seen so far in the current frame
    logic [SUM_W-1:0] tally_q;

    // Purpose: count carries per frame for the frame-total assertion
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tally_q <= '0;
        end else begin
            tally_q <= tally_q + {{MOD_W{1'b0}}, carry};
        end
    end

    // R2: each frame's carry total equals the modulation code
    p_frame_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> ((tally_q + {{MOD_W{1'b0}}, carry}) == {1'b0, mod_q}));

    // R4: a zero code never carries
    p_zero_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_q == '0) |-> !carry);

endmodule

// File: rtl/tapmod_select.sv
// Module tapmod_select
// Turns the carry into the tap applied this cycle: either the held base tap
// or the next one up. At the top tap code the upper choice is clamped to the
// base, so the upper flag stays low. Purely combinational; it assumes that
// the base tap is the held frame value.
module tapmod_select
    import tapmod_pkg::*;
#(
    parameter int TAP_W = 5
) (
    input  logic [TAP_W-1:0] base_tap,
    input  logic             want_upper,
    output logic [TAP_W-1:0] tap_out,
    output logic             upper_used
);

    localparam logic [TAP_W-1:0] TOP_TAP = '1;

    pick_e pick;

    // Purpose: pick base or upper tap, clamping at the top code
    always_comb begin
        if (want_upper && (base_tap != TOP_TAP)) begin
            pick = PICK_UPPER;
        end else begin
            pick = PICK_BASE;
        end
        tap_out    = (pick == PICK_UPPER) ? base_tap + 1'b1 : base_tap;
        upper_used = (pick == PICK_UPPER);
    end

endmodule

// File: rtl/tapmod_core.sv
// Module tapmod_core
// Top of the two-tap cycle modulator. It chooses the base tap n or the upper
// tap n+1 for every oscillator cycle. Over each repeating frame of 2**MOD_W
// cycles, the upper tap is used mod_q times, spread evenly. The codes are
// taken only at frame boundaries. It assumes that clk is the oscillator
// clock itself and that the reset is synchronous and active low.
module tapmod_core
    import tapmod_pkg::*;
#(
    parameter int TAP_W = TAPMOD_TAP_W,
    parameter int MOD_W = TAPMOD_MOD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAP_W-1:0] tap_code,
    input  logic [MOD_W-1:0] mod_code,
    output logic [TAP_W-1:0] sel_tap,
    output logic             upper_active,
    output logic             frame_start
);

    localparam logic [TAP_W-1:0] TOP_TAP = '1;

    logic             f_first;
    logic             f_last;
    logic [MOD_W-1:0] f_idx;
    logic [TAP_W-1:0] tap_q;
    logic [MOD_W-1:0] mod_q;
    logic             acc_carry;
    logic [TAP_W-1:0] tap_pick;
    logic             upper_pick;

    tapmod_frame_ctr #(.MOD_W(MOD_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_first (f_first),
        .frame_last  (f_last),
        .cyc_idx     (f_idx)
    );

    tapmod_code_hold #(.TAP_W(TAP_W), .MOD_W(MOD_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (f_last),
        .tap_in (tap_code),
        .mod_in (mod_code),
        .tap_q  (tap_q),
        .mod_q  (mod_q)
    );

    tapmod_accum #(.MOD_W(MOD_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (f_last),
        .mod_q   (mod_q),
        .carry   (acc_carry)
    );

    tapmod_select #(.TAP_W(TAP_W)) u_sel (
        .base_tap   (tap_q),
        .want_upper (acc_carry),
        .tap_out    (tap_pick),
        .upper_used (upper_pick)
    );

    // Purpose: drive the output ports from the selection stage
    always_comb begin
        sel_tap      = tap_pick;
        upper_active = upper_pick;
        frame_start  = f_first;
    end

    // R3: an upper cycle always applies the tap one above the held base
    p_adjacent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upper_active |-> (sel_tap == tap_q + 1'b1));

    // R3: a base cycle applies the held base tap itself
    p_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !upper_active |-> (sel_tap == tap_q));

    // R6: a saturated base tap pins the output at the top tap
    p_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_q == TOP_TAP) |-> (sel_tap == TOP_TAP && !upper_active));

    // R1: frame cycle 0 is the only cycle that flags a frame start
    p_start_idx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (f_idx == '0));

endmodule

// File: tb/sim_tapmod_core.sv
`timescale 1ns/1ps
// Bench for tapmod_core: directed corner frames, then random codes from a
// fixed seed. Every frame is checked cycle by cycle against bench functions.
module sim_tapmod_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] tap_code = '0;
    logic [4:0] mod_code = '0;
    logic [4:0] sel_tap;
    logic       upper_active;
    logic       frame_start;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    int  cur_n, cur_m;

    always #10 clk = ~clk;

    tapmod_core u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .tap_code     (tap_code),
        .mod_code     (mod_code),
        .sel_tap      (sel_tap),
        .upper_active (upper_active),
        .frame_start  (frame_start)
    );

    // Expected upper flag on frame cycle k, with the top-tap clamp
    function automatic int exp_up(int n, int m, int k);
        if (n == 31) return 0;
        return (((k + 1) * m) / 32 != (k * m) / 32) ? 1 : 0;
    endfunction

    function automatic int exp_sel(int n, int m, int k);
        return n + exp_up(n, m, k);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Check one frame of (n,m); drive the next codes (nn,nm) on cycle chg
    task automatic run_frame(int n, int m, int nn, int nm, int chg);
        int hits = 0;
        string tag;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            chk(frame_start == (k == 0), "R1 frame_start", frame_start, k == 0);
            tag = (n == 31) ? "R6 upper" : (m == 0) ? "R4 upper" : "R3 upper";
            chk(upper_active == exp_up(n, m, k), tag, upper_active, exp_up(n, m, k));
            tag = (n == 31) ? "R6 sel_tap" : (chg < k) ? "R5 sel_tap" : "R3 sel_tap";
            chk(sel_tap == exp_sel(n, m, k), tag, sel_tap, exp_sel(n, m, k));
            if (upper_active) hits++;
            if (k == chg) begin
                tap_code = nn[4:0];
                mod_code = nm[4:0];
            end
        end
        chk(hits == ((n == 31) ? 0 : m), "R2 upper count", hits, (n == 31) ? 0 : m);
        cur_n = nn;
        cur_m = nm;
    endtask

    // Hold reset for a few cycles and check the quiet outputs (R7)
    task automatic reset_phase(int n0, int m0);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            tap_code = 5'(i + 20);
            mod_code = 5'(i + 9);
            chk(sel_tap == 0, "R7 reset sel_tap", sel_tap, 0);
            chk(upper_active == 0, "R7 reset upper", upper_active, 0);
            chk(frame_start == 0, "R7 reset frame_start", frame_start, 0);
        end
        tap_code = n0[4:0];
        mod_code = m0[4:0];
        rst_n = 1'b1;
        cur_n = n0;
        cur_m = m0;
    endtask

    initial begin
        int seed;
        int nn, nm, chg;
        seed = $urandom(32'h1d5a);
        reset_phase(7, 13);
        // Directed corners: m = 0, 1, 16, 31; tap 30 and 31; early change
        run_frame(cur_n, cur_m, 4, 0, 3);
        run_frame(cur_n, cur_m, 12, 1, 31);
        run_frame(cur_n, cur_m, 30, 31, 0);
        run_frame(cur_n, cur_m, 31, 20, 16);
        run_frame(cur_n, cur_m, 31, 31, 5);
        run_frame(cur_n, cur_m, 0, 16, 28);
        run_frame(cur_n, cur_m, 18, 7, 2);
        // Reset in the middle of a frame, then restart (R7)
        for (int i = 0; i < 11; i++) @(negedge clk);
        reset_phase(9, 5);
        run_frame(cur_n, cur_m, 3, 29, 10);
        // Random codes with random change points (R5)
        for (int f = 0; f < 40; f++) begin
            nn  = $urandom_range(0, 31);
            nm  = $urandom_range(0, 31);
            chg = $urandom_range(0, 31);
            run_frame(cur_n, cur_m, nn, nm, chg);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule